// File: doc/BRIEF.md
# Masked Address Window Decoder

This block holds the configuration for three address windows and sorts incoming system addresses into them. Two windows are general memory windows, each described by a base register and a mask register; their size follows from the mask. The third is a fixed 4 KiB register-space window described by a base register only. An enable register switches each window on or off. Configuration travels over a 64-bit register bus that accepts only aligned 8-byte accesses.

The decode side takes one address per cycle and, one cycle later, returns a one-hot vector naming the window that was hit, together with the offset of the address inside that window. When windows overlap, the first memory window wins over the second, and both win over the register-space window. Writing a base or mask register while its own window is enabled is allowed but raises a one-cycle error pulse. Reset contents of the base registers are derived from two parameters, a chip index and a unit index, so that every instance of the block comes out of reset with its own non-overlapping windows.

Top module: `bar_window_decoder`

## Requirements
- R1: The register index is the byte address shifted right by 3: index 0 first memory base, 1 first memory mask, 2 second memory base, 3 second memory mask, 4 register-space base, 5 enable. An access is valid only when cfg_size is 8 and cfg_addr[2:0] is 0; an invalid write changes nothing, and an invalid read or a read of an index above 5 returns zero.
- R2: A write to either memory base or either mask stores only bits 63:30 of the data (the rest read back as zero).
- R3: A write to the register-space base stores only bits 63:26.
- R4: A write to the enable register stores only bits 63:59; bit 63 enables the first memory window, bit 62 the second, bit 61 the register-space window. A disabled window never hits.
- R5: After reset, with chip index c and unit index u, the bases hold (0x3D00000000000 + 0x4000000000·c + 0x1000000000·u), (0x3FF8000000000 + 0x200000000·c + 0x80000000·u) and (0x3FFFE40000000 + 0x400000·c + 0x100000·u), the masks hold 0x3FFF000000000 and 0x3FFFF80000000, each shifted left by 14; the enable register is zero.
- R6: A window's base is its base register shifted right by 14, a memory window's size is ((~mask) >> 14) + 1, and an address hits an enabled window when base <= addr < base + size.
- R7: The register-space window is 0x1000 bytes long.
- R8: hit_vec bit 0 marks the first memory window, bit 1 the second, bit 2 the register space; at most one bit is set, and on overlap the lowest bit wins.
- R9: hit_vld, hit_vec and hit_off appear one cycle after dec_valid/dec_addr; hit_off is addr minus the hit window's base, and zero on a miss; with dec_valid low nothing hits.
- R10: A write to a base or mask register whose window is enabled at that time pulses cfg_err high for one cycle after the write; the data is still stored. The same write to a disabled window leaves cfg_err low.
- R11: Read data appears on cfg_rdata with cfg_rvalid one cycle after the read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration access strobe |
| cfg_write | input | 1 | 1 for write, 0 for read |
| cfg_addr | input | CFG_AW | Byte address of the access |
| cfg_size | input | 4 | Access size in bytes |
| cfg_wdata | input | 64 | Write data |
| cfg_rvalid | output | 1 | Read response strobe |
| cfg_rdata | output | 64 | Read response data |
| cfg_err | output | 1 | Pulse: base or mask written while its window was enabled |
| dec_valid | input | 1 | Decode request strobe |
| dec_addr | input | 50 | System address to decode |
| hit_vld | output | 1 | Decode result strobe |
| hit_vec | output | 3 | One-hot window hit |
| hit_off | output | 50 | Offset inside the hit window |

## Verification
The bench builds the block with chip index 1 and unit index 2, so that both index terms of every reset base are non-zero and a swapped or dropped multiplier changes the decoded windows. With those values the three windows sit in widely separated regions, which lets the bench probe the first and last byte of each window and the byte just past it without another window interfering; overlap is then created on purpose by rewriting bases while windows are off.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
   localparam int unsigned DATA_W     = 64;
   localparam int unsigned ADDR_SHIFT = 14;
   localparam int unsigned PA_W       = DATA_W - ADDR_SHIFT;
   localparam int unsigned NWIN       = 3;
   localparam int unsigned NMMIO      = 2;
   localparam int unsigned NREG       = 6;
   localparam int unsigned RS_SIZE    = 4096;
   localparam logic [3:0]  ACC_BYTES  = 4'd8;

   typedef enum int unsigned {
      IDX_B0 = 0,
      IDX_M0 = 1,
      IDX_B1 = 2,
      IDX_M1 = 3,
      IDX_RS = 4,
      IDX_EN = 5
   } reg_idx_e;

   localparam logic [DATA_W-1:0] WM_MMIO = 64'hFFFF_FFFF_C000_0000;
   localparam logic [DATA_W-1:0] WM_RS   = 64'hFFFF_FFFF_FC00_0000;
   localparam logic [DATA_W-1:0] WM_EN   = 64'hF800_0000_0000_0000;

   function automatic logic [DATA_W-1:0] write_mask(input int unsigned idx);
      case (idx)
         IDX_B0, IDX_M0, IDX_B1, IDX_M1: return WM_MMIO;
         IDX_RS:                         return WM_RS;
         IDX_EN:                         return WM_EN;
         default:                        return '0;
      endcase
   endfunction

   function automatic logic [DATA_W-1:0] reset_value(input int unsigned idx,
                                                    input int unsigned chip,
                                                    input int unsigned unit);
      logic [DATA_W-1:0] c;
      logic [DATA_W-1:0] u;
      logic [DATA_W-1:0] v;
      c = DATA_W'(chip);
      u = DATA_W'(unit);
      case (idx)
         IDX_B0:  v = 64'h3D00_0000_0000 * 64'd16 + c * 64'h40_0000_0000 + u * 64'h10_0000_0000;
         IDX_M0:  v = 64'h3FFF_0000_0000_0 >> 0;
         IDX_B1:  v = 64'h3FF8_0000_0000_0 + c * 64'h2_0000_0000 + u * 64'h8000_0000;
         IDX_M1:  v = 64'h3FFF_F800_0000_0;
         IDX_RS:  v = 64'h3FFF_E400_0000_0 + c * 64'h40_0000 + u * 64'h10_0000;
         default: v = '0;
      endcase
      return v << ADDR_SHIFT;
   endfunction
endpackage

// File: rtl/bwd_cfg_regs.sv
module bwd_cfg_regs
   import bwd_pkg::*;
#(
   parameter int unsigned CHIP_IDX = 0,
   parameter int unsigned UNIT_IDX = 0,
   parameter int unsigned CFG_AW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic              cfg_write,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [3:0]        cfg_size,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic              cfg_rvalid,
   output logic [DATA_W-1:0] cfg_rdata,
   output logic              cfg_err,
   output logic [DATA_W-1:0] base_raw [NWIN],
   output logic [DATA_W-1:0] mask_raw [NMMIO],
   output logic [NWIN-1:0]   win_en
);
   localparam int unsigned IDX_W = CFG_AW - 3;

   logic [DATA_W-1:0] regs_q [NREG];
   logic [IDX_W-1:0]  idx;
   logic              acc_ok;
   logic              wr_en;
   logic              err_d;
   logic [DATA_W-1:0] rd_d;

   assign idx    = cfg_addr[CFG_AW-1:3];
   assign acc_ok = cfg_valid && (cfg_size == ACC_BYTES) && (cfg_addr[2:0] == 3'b000);
   assign wr_en  = acc_ok && cfg_write;

   // enable bits: 63 -> window 0, 62 -> window 1, 61 -> window 2
   always_comb begin
      for (int w = 0; w < NWIN; w++) begin
         win_en[w] = regs_q[IDX_EN][DATA_W-1-w];
      end
   end

   assign base_raw[0] = regs_q[IDX_B0];
   assign base_raw[1] = regs_q[IDX_B1];
   assign base_raw[2] = regs_q[IDX_RS];
   assign mask_raw[0] = regs_q[IDX_M0];
   assign mask_raw[1] = regs_q[IDX_M1];

   always_comb begin
      err_d = 1'b0;
      if (wr_en) begin
         if ((idx == IDX_W'(IDX_B0) || idx == IDX_W'(IDX_M0)) && win_en[0]) err_d = 1'b1;
         if ((idx == IDX_W'(IDX_B1) || idx == IDX_W'(IDX_M1)) && win_en[1]) err_d = 1'b1;
         if ((idx == IDX_W'(IDX_RS)) && win_en[2])                          err_d = 1'b1;
      end
   end

   always_comb begin
      rd_d = '0;
      for (int i = 0; i < NREG; i++) begin
         if (acc_ok && idx == IDX_W'(i)) rd_d = regs_q[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) begin
            regs_q[i] <= reset_value(i, CHIP_IDX, UNIT_IDX);
         end
         cfg_err    <= 1'b0;
         cfg_rvalid <= 1'b0;
         cfg_rdata  <= '0;
      end else begin
         for (int i = 0; i < NREG; i++) begin
            if (wr_en && idx == IDX_W'(i)) regs_q[i] <= cfg_wdata & write_mask(i);
         end
         cfg_err    <= err_d;
         cfg_rvalid <= cfg_valid && !cfg_write;
         cfg_rdata  <= cfg_write ? '0 : rd_d;
      end
   end
endmodule

// File: rtl/bwd_win_match.sv
module bwd_win_match
   import bwd_pkg::*;
#(
   parameter int unsigned FIXED_SIZE = 0
) (
   input  logic [PA_W-1:0]   addr,
   input  logic [DATA_W-1:0] base_raw,
   input  logic [DATA_W-1:0] mask_raw,
   input  logic              en,
   output logic              hit,
   output logic [PA_W-1:0]   off
);
   logic [PA_W-1:0] base;
   logic [PA_W:0]   size;
   logic [PA_W:0]   diff;
   logic            unused_low;

   assign base       = base_raw[DATA_W-1:ADDR_SHIFT];
   assign unused_low = ^base_raw[ADDR_SHIFT-1:0];

   generate
      if (FIXED_SIZE == 0) begin : g_masked
         logic unused_mlow;
         assign unused_mlow = ^mask_raw[ADDR_SHIFT-1:0];
         assign size = {1'b0, ~mask_raw[DATA_W-1:ADDR_SHIFT]} + 1'b1;
      end else begin : g_fixed
         logic unused_mask;
         assign unused_mask = ^mask_raw;
         assign size = (PA_W+1)'(FIXED_SIZE);
      end
   endgenerate

   assign diff = {1'b0, addr} - {1'b0, base};
   assign hit  = en && (addr >= base) && (diff < size);
   assign off  = diff[PA_W-1:0];
endmodule

// File: rtl/bar_window_decoder.sv
module bar_window_decoder
   import bwd_pkg::*;
#(
   parameter int unsigned CHIP_IDX = 0,
   parameter int unsigned UNIT_IDX = 0,
   parameter int unsigned CFG_AW   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic              cfg_write,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [3:0]        cfg_size,
   input  logic [63:0]       cfg_wdata,
   output logic              cfg_rvalid,
   output logic [63:0]       cfg_rdata,
   output logic              cfg_err,
   input  logic              dec_valid,
   input  logic [49:0]       dec_addr,
   output logic              hit_vld,
   output logic [2:0]        hit_vec,
   output logic [49:0]       hit_off
);
   generate
      if (CHIP_IDX > 7)   begin : g_bad_chip $error("CHIP_IDX must be below 8"); end
      if (UNIT_IDX > 3)   begin : g_bad_unit $error("UNIT_IDX must be below 4"); end
      if (CFG_AW < 6)     begin : g_bad_aw   $error("CFG_AW must cover six registers"); end
      if (PA_W != 50)     begin : g_bad_pa   $error("address width mismatch"); end
   endgenerate

   logic [DATA_W-1:0] base_raw [NWIN];
   logic [DATA_W-1:0] mask_raw [NMMIO];
   logic [NWIN-1:0]   win_en;
   logic [NWIN-1:0]   win_hit;
   logic [PA_W-1:0]   win_off [NWIN];
   logic [NWIN-1:0]   sel_d;
   logic [PA_W-1:0]   off_d;

   bwd_cfg_regs #(
      .CHIP_IDX (CHIP_IDX),
      .UNIT_IDX (UNIT_IDX),
      .CFG_AW   (CFG_AW)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_valid  (cfg_valid),
      .cfg_write  (cfg_write),
      .cfg_addr   (cfg_addr),
      .cfg_size   (cfg_size),
      .cfg_wdata  (cfg_wdata),
      .cfg_rvalid (cfg_rvalid),
      .cfg_rdata  (cfg_rdata),
      .cfg_err    (cfg_err),
      .base_raw   (base_raw),
      .mask_raw   (mask_raw),
      .win_en     (win_en)
   );

   generate
      for (genvar w = 0; w < NWIN; w++) begin : g_win
         if (w < NMMIO) begin : g_mmio
            bwd_win_match #(.FIXED_SIZE(0)) match_i (
               .addr     (dec_addr),
               .base_raw (base_raw[w]),
               .mask_raw (mask_raw[w]),
               .en       (win_en[w]),
               .hit      (win_hit[w]),
               .off      (win_off[w])
            );
         end else begin : g_regspace
            bwd_win_match #(.FIXED_SIZE(RS_SIZE)) match_i (
               .addr     (dec_addr),
               .base_raw (base_raw[w]),
               .mask_raw ('0),
               .en       (win_en[w]),
               .hit      (win_hit[w]),
               .off      (win_off[w])
            );
         end
      end
   endgenerate

   // lowest window index wins
   always_comb begin
      sel_d = '0;
      off_d = '0;
      for (int w = NWIN - 1; w >= 0; w--) begin
         if (dec_valid && win_hit[w]) begin
            sel_d    = '0;
            sel_d[w] = 1'b1;
            off_d    = win_off[w];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit_vld <= 1'b0;
         hit_vec <= '0;
         hit_off <= '0;
      end else begin
         hit_vld <= dec_valid;
         hit_vec <= sel_d;
         hit_off <= off_d;
      end
   end
endmodule

// File: rtl/bwd_chk.sv
module bwd_chk #(
   parameter int unsigned CFG_AW = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_valid,
   input logic              cfg_write,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [3:0]        cfg_size,
   input logic              cfg_rvalid,
   input logic [63:0]       cfg_rdata,
   input logic              cfg_err,
   input logic              dec_valid,
   input logic              hit_vld,
   input logic [2:0]        hit_vec
);
   // R8
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R9
   idle_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |=> (hit_vec == 3'b000) && !hit_vld);

   // R9
   vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_valid |=> hit_vld);

   // R11
   rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_write) |=> cfg_rvalid);

   // R11
   rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rvalid |-> $past(cfg_valid && !cfg_write));

   // R10
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cfg_valid && cfg_write));

   // R1
   bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_write && (cfg_size != 4'd8 || cfg_addr[2:0] != 3'b000))
      |=> (cfg_rdata == 64'd0));
endmodule

bind bar_window_decoder bwd_chk #(.CFG_AW(CFG_AW)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_valid  (cfg_valid),
   .cfg_write  (cfg_write),
   .cfg_addr   (cfg_addr),
   .cfg_size   (cfg_size),
   .cfg_rvalid (cfg_rvalid),
   .cfg_rdata  (cfg_rdata),
   .cfg_err    (cfg_err),
   .dec_valid  (dec_valid),
   .hit_vld    (hit_vld),
   .hit_vec    (hit_vec)
);

// File: tb/bar_window_decoder_tb_top.sv
module bar_window_decoder_tb_top;
   localparam int unsigned CHIP = 1;
   localparam int unsigned UNIT = 2;

   localparam logic [63:0] B0_EFF = 64'h3D00000000000 + 64'h4000000000 * CHIP + 64'h1000000000 * UNIT;
   localparam logic [63:0] B1_EFF = 64'h3FF8000000000 + 64'h200000000 * CHIP + 64'h80000000 * UNIT;
   localparam logic [63:0] RS_EFF = 64'h3FFFE40000000 + 64'h400000 * CHIP + 64'h100000 * UNIT;
   localparam logic [63:0] M0_EFF = 64'h3FFF000000000;
   localparam logic [63:0] M1_EFF = 64'h3FFFF80000000;
   localparam logic [63:0] SZ0    = 64'h1000000000;
   localparam logic [63:0] SZ1    = 64'h80000000;
   localparam logic [63:0] SZRS   = 64'h1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_valid = 1'b0;
   logic        cfg_write = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [3:0]  cfg_size = 4'd8;
   logic [63:0] cfg_wdata = '0;
   logic        cfg_rvalid;
   logic [63:0] cfg_rdata;
   logic        cfg_err;
   logic        dec_valid = 1'b0;
   logic [49:0] dec_addr = '0;
   logic        hit_vld;
   logic [2:0]  hit_vec;
   logic [49:0] hit_off;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   bar_window_decoder #(.CHIP_IDX(CHIP), .UNIT_IDX(UNIT), .CFG_AW(8)) dut_i (.*);

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [7:0] a, input logic [63:0] d, input logic [3:0] sz, output logic err);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_write = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_size = sz;
      @(negedge clk);
      cfg_valid = 1'b0; cfg_write = 1'b0; cfg_size = 4'd8;
      err = cfg_err;
   endtask

   task automatic cfg_rd(input logic [7:0] a, input logic [3:0] sz, output logic [63:0] d);
      @(negedge clk);
      cfg_valid = 1'b1; cfg_write = 1'b0; cfg_addr = a; cfg_size = sz;
      @(negedge clk);
      cfg_valid = 1'b0; cfg_size = 4'd8;
      check(cfg_rvalid == 1'b1, "R11 rvalid", 64'(cfg_rvalid), 64'd1);
      d = cfg_rdata;
   endtask

   task automatic dec(input logic [63:0] a, input logic v, input logic [2:0] exp_vec, input logic [63:0] exp_off, input string req);
      @(negedge clk);
      dec_valid = v; dec_addr = a[49:0];
      @(negedge clk);
      dec_valid = 1'b0;
      check(hit_vld == v, {req, " hit_vld"}, 64'(hit_vld), 64'(v));
      check(hit_vec == exp_vec, {req, " hit_vec"}, 64'(hit_vec), 64'(exp_vec));
      check(hit_off == exp_off[49:0], {req, " hit_off"}, 64'(hit_off), exp_off);
   endtask

   task automatic wr_ok(input logic [7:0] a, input logic [63:0] d);
      logic e;
      cfg_wr(a, d, 4'd8, e);
   endtask

   task automatic t_reset;
      logic [63:0] d;
      cfg_rd(8'h00, 4'd8, d); check(d == (B0_EFF << 14), "R5 base0", d, B0_EFF << 14);
      cfg_rd(8'h08, 4'd8, d); check(d == (M0_EFF << 14), "R5 mask0", d, M0_EFF << 14);
      cfg_rd(8'h10, 4'd8, d); check(d == (B1_EFF << 14), "R5 base1", d, B1_EFF << 14);
      cfg_rd(8'h18, 4'd8, d); check(d == (M1_EFF << 14), "R5 mask1", d, M1_EFF << 14);
      cfg_rd(8'h20, 4'd8, d); check(d == (RS_EFF << 14), "R5 rsbase", d, RS_EFF << 14);
      cfg_rd(8'h28, 4'd8, d); check(d == 64'd0, "R5 enable", d, 64'd0);
      dec(B0_EFF, 1'b1, 3'b000, 64'd0, "R4 disabled window0");
      dec(RS_EFF, 1'b1, 3'b000, 64'd0, "R4 disabled regspace");
   endtask

   task automatic t_masks;
      logic [63:0] d;
      logic e;
      cfg_wr(8'h18, '1, 4'd8, e);
      check(e == 1'b0, "R10 no err when disabled", 64'(e), 64'd0);
      cfg_rd(8'h18, 4'd8, d); check(d == 64'hFFFFFFFFC0000000, "R2 mask1 write mask", d, 64'hFFFFFFFFC0000000);
      wr_ok(8'h18, M1_EFF << 14);
      cfg_wr(8'h20, '1, 4'd8, e);
      cfg_rd(8'h20, 4'd8, d); check(d == 64'hFFFFFFFFFC000000, "R3 rsbase write mask", d, 64'hFFFFFFFFFC000000);
      wr_ok(8'h20, RS_EFF << 14);
      wr_ok(8'h28, '1);
      cfg_rd(8'h28, 4'd8, d); check(d == 64'hF800000000000000, "R4 enable write mask", d, 64'hF800000000000000);
      wr_ok(8'h28, 64'd0);
   endtask

   task automatic t_access;
      logic [63:0] d;
      logic e;
      cfg_wr(8'h00, 64'h1234_5678_0000_0000, 4'd4, e);
      cfg_rd(8'h00, 4'd8, d); check(d == (B0_EFF << 14), "R1 short write dropped", d, B0_EFF << 14);
      cfg_wr(8'h01, 64'h1234_5678_0000_0000, 4'd8, e);
      cfg_rd(8'h00, 4'd8, d); check(d == (B0_EFF << 14), "R1 misaligned write dropped", d, B0_EFF << 14);
      cfg_rd(8'h00, 4'd4, d); check(d == 64'd0, "R1 short read zero", d, 64'd0);
      cfg_rd(8'h38, 4'd8, d); check(d == 64'd0, "R1 unmapped read zero", d, 64'd0);
   endtask

   task automatic t_decode;
      wr_ok(8'h28, 64'h8000_0000_0000_0000);
      dec(B0_EFF, 1'b1, 3'b001, 64'd0, "R6 window0 first byte");
      dec(B0_EFF + SZ0 - 1, 1'b1, 3'b001, SZ0 - 1, "R6 window0 last byte");
      dec(B0_EFF + SZ0, 1'b1, 3'b000, 64'd0, "R6 window0 past end");
      dec(B0_EFF - 1, 1'b1, 3'b000, 64'd0, "R6 window0 below base");
      dec(B0_EFF + 64'h40, 1'b0, 3'b000, 64'd0, "R9 no valid no hit");
      wr_ok(8'h28, 64'h4000_0000_0000_0000);
      dec(B1_EFF + 64'h1234, 1'b1, 3'b010, 64'h1234, "R6 window1 inside");
      dec(B1_EFF + SZ1, 1'b1, 3'b000, 64'd0, "R6 window1 past end");
      wr_ok(8'h28, 64'h2000_0000_0000_0000);
      dec(RS_EFF + SZRS - 1, 1'b1, 3'b100, SZRS - 1, "R7 regspace last byte");
      dec(RS_EFF + SZRS, 1'b1, 3'b000, 64'd0, "R7 regspace past end");
   endtask

   task automatic t_priority;
      wr_ok(8'h28, 64'd0);
      wr_ok(8'h10, B0_EFF << 14);
      wr_ok(8'h20, B0_EFF << 14);
      wr_ok(8'h28, 64'hE000_0000_0000_0000);
      dec(B0_EFF + 5, 1'b1, 3'b001, 64'd5, "R8 window0 over all");
      wr_ok(8'h28, 64'h6000_0000_0000_0000);
      dec(B0_EFF + 5, 1'b1, 3'b010, 64'd5, "R8 window1 over regspace");
      wr_ok(8'h28, 64'h2000_0000_0000_0000);
      dec(B0_EFF + 5, 1'b1, 3'b100, 64'd5, "R8 regspace alone");
   endtask

   task automatic t_err;
      logic [63:0] d;
      logic e;
      wr_ok(8'h28, 64'h8000_0000_0000_0000);
      cfg_wr(8'h08, 64'hFFFE_0000_0000_0000, 4'd8, e);
      check(e == 1'b1, "R10 err on enabled mask write", 64'(e), 64'd1);
      @(negedge clk);
      check(cfg_err == 1'b0, "R10 err single pulse", 64'(cfg_err), 64'd0);
      cfg_rd(8'h08, 4'd8, d); check(d == 64'hFFFE_0000_0000_0000, "R10 write still stored", d, 64'hFFFE_0000_0000_0000);
      cfg_wr(8'h10, B1_EFF << 14, 4'd8, e);
      check(e == 1'b0, "R10 no err other window", 64'(e), 64'd0);
      wr_ok(8'h28, 64'h2000_0000_0000_0000);
      cfg_wr(8'h20, RS_EFF << 14, 4'd8, e);
      check(e == 1'b1, "R10 err on enabled regspace base", 64'(e), 64'd1);
   endtask

   initial begin
      #400000;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(hit_vld == 1'b0 && hit_vec == 3'b000, "R9 reset outputs", 64'(hit_vec), 64'd0);
      check(cfg_err == 1'b0, "R10 reset err", 64'(cfg_err), 64'd0);
      t_reset();
      t_masks();
      t_access();
      t_decode();
      t_priority();
      t_err();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule